// File: doc/BRIEF.md
# Dual-Half Hamming ECC Generator

This block sits beside the byte-wide data path of a NAND flash controller. It computes single-error-correcting Hamming parity over a 512-byte page. The page is handled as two independent 256-byte halves. Each half collects 16 line-parity bits and 6 column-parity bits. Software drives the block through writes to a mode register. One mode code clears the accumulators. A data-port read and a second code then start accumulation over every byte that passes. A third code switches the 16-bit data port so that it returns the six result bytes as three words.

Comparing syndromes and repairing data is left to the host. Each half can locate one flipped bit, so a page can be repaired in up to two places.

Top module: `ecc_dual_hamming`

## Requirements
- R1: After reset the block is in plain data mode and `rd_data_o` is 0. Entering readout with nothing accumulated returns the words 0x0000, 0x0003 and 0x0300.
- R2: A mode write of 0xF4 clears all parity and the byte position. Results that were collected before it are no longer visible.
- R3: A mode write of 0xB4 starts accumulation only if at least one data-port read (`rd_i`) happened after the last 0xF4, with no other mode write in between. Otherwise the block drops to data mode and later bytes are not accumulated.
- R4: While accumulating, bytes 0..255 go to half 0 and bytes 256..511 go to half 1, each at in-half address 0..255. Any byte after the 512th is ignored until the next 0xF4.
- R5: For each byte at in-half address a, the byte's XOR parity is folded into line-parity bit 2k+1 when a[k]=1, and into bit 2k when a[k]=0, for k=0..7. The result is even parity, with no inversion.
- R6: Column parity bit 2j+1 (or 2j) is the XOR over all bytes of the half of the data bits whose bit index has bit j equal to 1 (or 0), for j=0..2. The column byte is {CP5..CP0, 2'b11}, so its bits 1:0 always read 1.
- R7: A mode write of 0xD4 selects readout starting at word 0. Each `rd_i` pulse moves to the next word, and the order wraps back to word 0 after word 2. The words, written {high byte, low byte}, are: word 0 = {LP15..8 h0, LP7..0 h0}; word 1 = {LP7..0 h1, column byte h0}; word 2 = {column byte h1, LP15..8 h1}.
- R8: Outside readout, `rd_data_o` is 0. Bytes that arrive outside accumulation change no parity.
- R9: Any mode write other than 0xF4, 0xB4 or 0xD4 (for example 0x94) returns the block to data mode. The stored parity is kept, and a later 0xD4 reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 8 | Mode code written |
| dat_vld_i | input | 1 | A byte passes the NAND data path this cycle |
| dat_i | input | 8 | The passing byte |
| rd_i | input | 1 | 16-bit data-port read strobe |
| rd_data_o | output | 16 | Result word while in readout, otherwise 0 |

## Verification
A wrong accumulator bit shows up only when the results are read out. It appears in exactly one of the three words, and which word depends on the half and on whether the bit is line or column parity. For that reason the pages are built so that a single byte or bit position flips a known parity bit. A position counter that is off by one moves a byte across the half boundary or past the 512-byte limit. That error changes both halves' words at the next readout. A wrong mode state is visible at once, because `rd_data_o` turns non-zero outside readout or accumulation fails to start after the dummy read.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [1:0] {
    ST_DATA   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_CALC   = 2'd2,
    ST_RESULT = 2'd3
  } ecc_st_e;

  localparam logic [7:0] MODE_CLR  = 8'hF4;
  localparam logic [7:0] MODE_CALC = 8'hB4;
  localparam logic [7:0] MODE_RES  = 8'hD4;

  // bit positions i of a DW-bit byte whose index has bit j set
  function automatic logic [7:0] col_mask(input int j);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = ((i >> j) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import ecc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [7:0] mode_i,
  input  logic       rd_i,
  output ecc_st_e    st_o,
  output logic       armed_rd_o,
  output logic       clr_o,
  output logic       res_entry_o
);
  ecc_st_e st_q;
  logic    armed_rd_q;

  assign clr_o       = mode_we_i && (mode_i == MODE_CLR);
  assign res_entry_o = mode_we_i && (mode_i == MODE_RES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_DATA;
      armed_rd_q <= 1'b0;
    end else if (mode_we_i) begin
      armed_rd_q <= 1'b0;
      unique case (mode_i)
        MODE_CLR:  st_q <= ST_ARMED;
        MODE_CALC: st_q <= (st_q == ST_ARMED && armed_rd_q) ? ST_CALC : ST_DATA;
        MODE_RES:  st_q <= ST_RESULT;
        default:   st_q <= ST_DATA;
      endcase
    end else if (rd_i && st_q == ST_ARMED) begin
      armed_rd_q <= 1'b1;
    end
  end

  assign st_o       = st_q;
  assign armed_rd_o = armed_rd_q;
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import ecc_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 8,
  localparam int LPW = 2 * AW,
  localparam int IW  = $clog2(DW),
  localparam int CPW = 2 * IW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  dat_i,
  output logic [LPW-1:0] lp_o,
  output logic [CPW-1:0] cp_o
);
  logic [LPW-1:0] lp_q, lp_d;
  logic [CPW-1:0] cp_q, cp_d;
  logic           bpar;

  assign bpar = ^dat_i;

  for (genvar k = 0; k < AW; k++) begin : g_lp
    assign lp_d[2*k+1] = lp_q[2*k+1] ^ (bpar &  addr_i[k]);
    assign lp_d[2*k]   = lp_q[2*k]   ^ (bpar & ~addr_i[k]);
  end

  for (genvar j = 0; j < IW; j++) begin : g_cp
    localparam logic [DW-1:0] MSK = DW'(col_mask(j));
    assign cp_d[2*j+1] = cp_q[2*j+1] ^ (^(dat_i &  MSK));
    assign cp_d[2*j]   = cp_q[2*j]   ^ (^(dat_i & ~MSK));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr_i) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (en_i) begin
      lp_q <= lp_d;
      cp_q <= cp_d;
    end
  end

  assign lp_o = lp_q;
  assign cp_o = cp_q;
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import ecc_pkg::*;
#(
  parameter int LPW = 16,
  parameter int CPW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  ecc_st_e        st_i,
  input  logic           res_entry_i,
  input  logic           rd_i,
  input  logic [LPW-1:0] lp0_i,
  input  logic [CPW-1:0] cp0_i,
  input  logic [LPW-1:0] lp1_i,
  input  logic [CPW-1:0] cp1_i,
  output logic [1:0]     idx_o,
  output logic [15:0]    rd_data_o
);
  logic [1:0]  idx_q;
  logic [15:0] lp0, lp1;
  logic [7:0]  col0, col1;
  logic [15:0] word;

  assign lp0  = 16'(lp0_i);
  assign lp1  = 16'(lp1_i);
  assign col0 = {cp0_i, {(8 - CPW){1'b1}}};
  assign col1 = {cp1_i, {(8 - CPW){1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idx_q <= 2'd0;
    else if (res_entry_i)                idx_q <= 2'd0;
    else if (st_i == ST_RESULT && rd_i)  idx_q <= (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
  end

  always_comb begin
    unique case (idx_q)
      2'd0:    word = {lp0[15:8], lp0[7:0]};
      2'd1:    word = {lp1[7:0], col0};
      default: word = {col1, lp1[15:8]};
    endcase
  end

  assign rd_data_o = (st_i == ST_RESULT) ? word : 16'h0000;
  assign idx_o     = idx_q;
endmodule

// File: rtl/ecc_dual_hamming.sv
module ecc_dual_hamming
  import ecc_pkg::*;
#(
  parameter int HALF_BYTES = 256,
  parameter int DW         = 8,
  localparam int AW  = $clog2(HALF_BYTES),
  localparam int LPW = 2 * AW,
  localparam int CPW = 2 * $clog2(DW),
  localparam int NH  = 2,
  localparam int CW  = AW + 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_we_i,
  input  logic [7:0]  mode_i,
  input  logic        dat_vld_i,
  input  logic [7:0]  dat_i,
  input  logic        rd_i,
  output logic [15:0] rd_data_o
);
  localparam logic [CW-1:0] PAGE_BYTES = CW'(NH * HALF_BYTES);

  ecc_st_e        st;
  logic           armed_rd, clr, res_entry, take;
  logic [CW-1:0]  byte_cnt_q;
  logic [1:0]     rd_idx;
  logic [LPW-1:0] lp [NH];
  logic [CPW-1:0] cp [NH];

  ecc_mode_ctrl i_ctrl (
    .clk_i, .rst_ni, .mode_we_i, .mode_i, .rd_i,
    .st_o(st), .armed_rd_o(armed_rd), .clr_o(clr), .res_entry_o(res_entry)
  );

  assign take = (st == ST_CALC) && dat_vld_i && (byte_cnt_q < PAGE_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   byte_cnt_q <= '0;
    else if (clr)  byte_cnt_q <= '0;
    else if (take) byte_cnt_q <= byte_cnt_q + 1'b1;
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    ecc_half_acc #(.AW(AW), .DW(DW)) i_acc (
      .clk_i, .rst_ni,
      .clr_i (clr),
      .en_i  (take && (byte_cnt_q[AW] == 1'(h))),
      .addr_i(byte_cnt_q[AW-1:0]),
      .dat_i (dat_i[DW-1:0]),
      .lp_o  (lp[h]),
      .cp_o  (cp[h])
    );
  end

  ecc_readout #(.LPW(LPW), .CPW(CPW)) i_rdo (
    .clk_i, .rst_ni,
    .st_i(st), .res_entry_i(res_entry), .rd_i,
    .lp0_i(lp[0]), .cp0_i(cp[0]), .lp1_i(lp[1]), .cp1_i(cp[1]),
    .idx_o(rd_idx), .rd_data_o
  );
endmodule

// File: rtl/ecc_dual_hamming_chk.sv
module ecc_dual_hamming_chk
  import ecc_pkg::*;
#(
  parameter int CW = 10,
  parameter int PAGE = 512
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_we_i,
  input logic [7:0]    mode_i,
  input logic          rd_i,
  input logic [15:0]   rd_data_o,
  input ecc_st_e       st,
  input logic          armed_rd,
  input logic [CW-1:0] byte_cnt_q,
  input logic [1:0]    rd_idx
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_RESULT) |-> (rd_data_o == 16'h0)); // R8
  AST_CALC_NEEDS_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_i == MODE_CALC && !armed_rd) |=> (st == ST_DATA)); // R3
  AST_CLR_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_i == MODE_CLR) |=> (byte_cnt_q == '0 && st == ST_ARMED)); // R2
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_q <= CW'(PAGE)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_CALC && !(mode_we_i && mode_i == MODE_CLR)) |=> $stable(byte_cnt_q)); // R8
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RESULT && !mode_we_i && rd_i && rd_idx == 2'd2) |=> (rd_idx == 2'd0)); // R7
  AST_COL0_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RESULT && rd_idx == 2'd1) |-> (rd_data_o[1:0] == 2'b11)); // R6
  AST_COL1_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RESULT && rd_idx == 2'd2) |-> (rd_data_o[9:8] == 2'b11)); // R6
endmodule

bind ecc_dual_hamming ecc_dual_hamming_chk #(.CW(CW), .PAGE(NH * HALF_BYTES)) i_chk (
  .clk_i, .rst_ni, .mode_we_i, .mode_i, .rd_i, .rd_data_o,
  .st, .armed_rd, .byte_cnt_q, .rd_idx
);

// File: tb/test_ecc_dual_hamming.sv
`timescale 1ns/1ps
module test_ecc_dual_hamming;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic [7:0]  mode_i = 8'h00;
  logic        dat_vld_i = 1'b0;
  logic [7:0]  dat_i = 8'h00;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  page [0:511];

  always #10 clk_i = ~clk_i;

  ecc_dual_hamming i_ecc_dual_hamming (.*);

  // monitor: one expected item per read strobe
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rd_i) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (rd_data_o !== e) begin
          bad++;
          $display("FAIL %s: rd_data_o=%h expected=%h", t, rd_data_o, e);
        end
      end
    end
  end

  task automatic write_mode(input logic [7:0] m);
    @(negedge clk_i);
    mode_we_i = 1'b1; mode_i = m;
    @(negedge clk_i);
    mode_we_i = 1'b0;
  endtask

  task automatic read_word(input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  function automatic logic [7:0] gen_byte(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + (i >> 3) * seed) ^ (i >> 5));
  endfunction

  task automatic clear_page();
    for (int i = 0; i < 512; i++) page[i] = 8'h00;
  endtask

  // mode 0: generated bytes; mode 1: zeros except page[] preset
  task automatic send_bytes(input int n, input int seed, input bit use_page);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = use_page ? ((i < 512) ? page[i] : 8'h5A) : gen_byte(i, seed);
      if (!use_page && i < 512) page[i] = b;
      @(negedge clk_i);
      dat_vld_i = 1'b1; dat_i = b;
    end
    @(negedge clk_i);
    dat_vld_i = 1'b0;
  endtask

  function automatic logic [21:0] half_par(input int base);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] b;
      b = page[base + a];
      for (int k = 0; k < 8; k++)
        if (((a >> k) & 1) == 1) lp[2*k+1] ^= ^b; else lp[2*k] ^= ^b;
      for (int i = 0; i < 8; i++)
        if (b[i])
          for (int j = 0; j < 3; j++)
            if (((i >> j) & 1) == 1) cp[2*j+1] ^= 1'b1; else cp[2*j] ^= 1'b1;
    end
    return {cp, lp};
  endfunction

  task automatic read_results(input string t);
    logic [21:0] h0, h1;
    h0 = half_par(0);
    h1 = half_par(256);
    write_mode(8'hD4);
    read_word(h0[15:0], {t, " word0"});
    read_word({h1[7:0], h0[21:16], 2'b11}, {t, " word1"});
    read_word({h1[21:16], 2'b11, h1[15:8]}, {t, " word2"});
  endtask

  task automatic start_calc();
    write_mode(8'hF4);
    read_word(16'h0000, "R3 dummy read in armed mode");
    write_mode(8'hB4);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk_i);
        rst_ni = 1'b1;
        // R1: reset state
        read_word(16'h0000, "R1 data mode after reset");
        clear_page();
        read_results("R1 empty result");
        read_word(16'h0000, "R7 wrap to word0");
        // R4 R5 R6 R7: full page
        start_calc();
        send_bytes(512, 3, 1'b0);
        read_results("R5 R6 full page");
        // R9 + R8: leave to data mode, bytes ignored, results kept
        write_mode(8'h94);
        read_word(16'h0000, "R8 no output in data mode");
        send_bytes(40, 9, 1'b1);
        read_results("R9 kept after 0x94");
        // R3: no dummy read -> no accumulation; R2 cleared
        write_mode(8'hF4);
        write_mode(8'hB4);
        send_bytes(64, 5, 1'b0);
        clear_page();
        read_results("R2 R3 no dummy read");
        // R4: beyond 512 ignored
        clear_page();
        start_calc();
        send_bytes(520, 7, 1'b0);
        read_results("R4 overflow ignored");
        // R5 R6: single bits to locate parity positions
        clear_page();
        page[37] = 8'h20;
        page[300] = 8'h01;
        page[511] = 8'h80;
        start_calc();
        send_bytes(512, 0, 1'b1);
        read_results("R5 R6 single bits");
        // R4: partial page only fills half 0
        clear_page();
        start_calc();
        send_bytes(100, 2, 1'b0);
        read_results("R4 partial page");
        read_word(half_par(0) >> 0 & 16'hFFFF, "R7 wrap after word2");
        write_mode(8'h94);
        repeat (3) @(negedge clk_i);
        if (exp_q.size() != 0) begin
          total++; bad++;
          $display("FAIL R7: pending=%0d expected=0", exp_q.size());
        end
      end
      begin
        repeat (100000) @(negedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: cycles=100000 expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule